// File: doc/BRIEF.md
# Pointer-Addressed Register Slave on a Two-Wire Serial Bus

This block is the serial front end of a small sensor device. It sits on an open-drain I2C bus (SCL and SDA, each seen as an input level, with SDA pulled low through an output enable) and holds four 16-bit registers. A 2-bit pointer, loaded from the first byte of every write transaction, decides which register a later write or read touches. The pointer survives between transactions, so a master that polls one register only sends the pointer once.

Index 0 holds conversion results. The core loads it through a parallel load port, and the bus can only read it. Indices 1, 2 and 3 hold configuration and the low and high limits. The bus master can write them, and the core sees them on parallel outputs. Words travel high byte first in both directions. A read takes a snapshot of the whole selected word when the address is acknowledged, so both bytes of one read always belong to the same value.

Top module: `i2cptr_slave`

## Requirements
- R1: After reset the registers hold index 0 = 16'h0000, index 1 = 16'h8583, index 2 = 16'h8000 and index 3 = 16'h7FFF. The pointer holds 0 and SDA is released (sda_oe = 0).
- R2: The slave answers to the 7-bit address {5'b10010, addr_sel[1:0]}, sent MSB first with the R/W bit last (0 = write, 1 = read). It acknowledges a matching address by pulling SDA low on the ninth clock. For any other address it leaves SDA released for the whole transaction and changes no state.
- R3: In a write transaction, the first byte after the address is the pointer byte. Bits [1:0] of that byte become the pointer, the upper six bits are ignored, and the byte is acknowledged.
- R4: A write made of only the address and pointer byte, ended by STOP or by a repeated START, updates the pointer and leaves all four registers unchanged.
- R5: Data bytes after the pointer byte are acknowledged and form a word, high byte first. The word is written to the register the pointer names only once its second byte has been acknowledged. A lone first byte followed by STOP changes nothing.
- R6: A write whose pointer is 0 is acknowledged, but it leaves the conversion register unchanged.
- R7: A read transaction returns the register selected by the most recently written pointer, high byte first. The pointer keeps its value across any number of reads.
- R8: When the master leaves SDA high on the acknowledge bit after the first or the second read byte, the slave stops driving and keeps SDA released.
- R9: A one-cycle pulse on conv_load stores conv_data in the conversion register. A read transfers the word that was present when its address was acknowledged, even if a load happens during the transfer.
- R10: SCL and SDA pass through a two-flop synchronizer. A START or STOP at any bit position aborts the transaction in progress without updating the pointer or any register. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level on the bus clock line |
| sda_i | input | 1 | Level on the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 2 | Low two bits of the slave address |
| conv_load | input | 1 | Core strobe that stores conv_data |
| conv_data | input | 16 | New conversion result |
| conv_o | output | 16 | Conversion register view |
| cfg_o | output | 16 | Configuration register view |
| lo_thr_o | output | 16 | Low limit register view |
| hi_thr_o | output | 16 | High limit register view |

## Verification
The core can load a new conversion result while the bus master is reading the conversion register. The bench provokes this by pulsing conv_load in the middle of the first byte of a two-byte read. It judges the result by requiring that both bytes returned match the old word, and that the next read returns the new word. A second overlap is a STOP that arrives while a pointer byte is only half shifted in. The bench judges this by checking that the next read still uses the previous pointer.

// File: rtl/i2cptr_pkg.sv
package i2cptr_pkg;

    localparam int REG_W  = 16;
    localparam int PTR_W  = 2;
    localparam int BYTE_W = 8;

    localparam logic [REG_W-1:0] RST_CONV = 16'h0000;
    localparam logic [REG_W-1:0] RST_CFG  = 16'h8583;
    localparam logic [REG_W-1:0] RST_LO   = 16'h8000;
    localparam logic [REG_W-1:0] RST_HI   = 16'h7FFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXEND,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACKEND
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/i2cptr_sync.sv
module i2cptr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_pipe[0] = scl_i;
        d.sda_pipe[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            d.scl_pipe[i] = q.scl_pipe[i-1];
            d.sda_pipe[i] = q.sda_pipe[i-1];
        end
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_lvl_o  = q.scl_pipe[STAGES-1];
    assign sda_lvl_o  = q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_lvl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_lvl_o & q.scl_prev;
    assign start_o    = q.sda_prev & ~sda_lvl_o & scl_lvl_o & q.scl_prev;
    assign stop_o     = ~q.sda_prev & sda_lvl_o & scl_lvl_o & q.scl_prev;

endmodule

// File: rtl/i2cptr_engine.sv
module i2cptr_engine
    import i2cptr_pkg::*;
#(
    parameter int          W      = REG_W,
    parameter int          PW     = PTR_W,
    parameter int          ASEL_W = 2,
    parameter logic [4:0]  ADDR_HI = 5'b10010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ASEL_W-1:0] addr_sel_i,
    input  logic [W-1:0]      rd_word_i,
    output logic              sda_oe_o,
    output logic              ptr_we_o,
    output logic [PW-1:0]     ptr_val_o,
    output logic              wr_we_o,
    output logic [W-1:0]      wr_word_o
);

    localparam int NBYTES = W / BYTE_W;
    localparam int BCW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BCW-1:0] LAST_BYTE = BCW'(NBYTES - 1);

    typedef struct packed {
        bus_state_e      st;
        rx_phase_e       ph;
        logic [2:0]      bitcnt;
        logic [BYTE_W-1:0] sh;
        logic            rw;
        logic [BCW-1:0]  bidx;
        logic [W-1:0]    acc;
        logic [W-1:0]    tx;
        logic            oe;
        logic            ptr_we;
        logic [PW-1:0]   ptr;
        logic            wr_we;
        logic [W-1:0]    wr;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        d.ptr_we = 1'b0;
        d.wr_we  = 1'b0;
        if (start_i) begin
            d.st     = ST_RX;
            d.ph     = PH_ADDR;
            d.bitcnt = '0;
            d.bidx   = '0;
            d.oe     = 1'b0;
        end else if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: if (scl_rise_i) begin
                    d.sh = {q.sh[BYTE_W-2:0], sda_lvl_i};
                    if (q.bitcnt == 3'd7) d.st = ST_RXEND;
                    else                  d.bitcnt = q.bitcnt + 3'd1;
                end
                ST_RXEND: if (scl_fall_i) begin
                    d.bitcnt = '0;
                    case (q.ph)
                        PH_ADDR: begin
                            if (q.sh[BYTE_W-1:1] == {ADDR_HI, addr_sel_i}) begin
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                        PH_PTR: begin
                            d.ptr = q.sh[PW-1:0];
                            d.oe  = 1'b1;
                            d.st  = ST_ACK;
                        end
                        default: begin
                            d.acc = {q.acc[W-BYTE_W-1:0], q.sh};
                            d.oe  = 1'b1;
                            d.st  = ST_ACK;
                        end
                    endcase
                end
                ST_ACK: if (scl_fall_i) begin
                    d.oe = 1'b0;
                    d.st = ST_RX;
                    case (q.ph)
                        PH_ADDR: begin
                            if (q.rw) begin
                                d.tx   = rd_word_i;
                                d.oe   = ~rd_word_i[W-1];
                                d.bidx = '0;
                                d.st   = ST_TX;
                            end else begin
                                d.ph = PH_PTR;
                            end
                        end
                        PH_PTR: begin
                            d.ptr_we = 1'b1;
                            d.ph     = PH_DATA;
                            d.bidx   = '0;
                        end
                        default: begin
                            if (q.bidx == LAST_BYTE) begin
                                d.wr_we = 1'b1;
                                d.wr    = q.acc;
                                d.bidx  = '0;
                            end else begin
                                d.bidx = q.bidx + 1'b1;
                            end
                        end
                    endcase
                end
                ST_TX: if (scl_fall_i) begin
                    d.tx = q.tx << 1;
                    if (q.bitcnt == 3'd7) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        d.st     = ST_MACK;
                    end else begin
                        d.bitcnt = q.bitcnt + 3'd1;
                        d.oe     = ~q.tx[W-2];
                    end
                end
                ST_MACK: if (scl_rise_i) begin
                    d.st = sda_lvl_i ? ST_IDLE : ST_MACKEND;
                end
                ST_MACKEND: if (scl_fall_i) begin
                    d.st = ST_TX;
                    if (q.bidx == LAST_BYTE) begin
                        d.bidx = '0;
                        d.tx   = rd_word_i;
                        d.oe   = ~rd_word_i[W-1];
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                        d.oe   = ~q.tx[W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign ptr_we_o  = q.ptr_we;
    assign ptr_val_o = q.ptr;
    assign wr_we_o   = q.wr_we;
    assign wr_word_o = q.wr;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe_o); // R8
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_oe_o); // R10
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl_i); // R10

endmodule

// File: rtl/i2cptr_regfile.sv
module i2cptr_regfile
    import i2cptr_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we_i,
    input  logic [PW-1:0] ptr_val_i,
    input  logic          wr_we_i,
    input  logic [W-1:0]  wr_word_i,
    input  logic          conv_load_i,
    input  logic [W-1:0]  conv_data_i,
    output logic [W-1:0]  rd_word_o,
    output logic [W-1:0]  conv_o,
    output logic [W-1:0]  cfg_o,
    output logic [W-1:0]  lo_o,
    output logic [W-1:0]  hi_o
);

    localparam int NREGS = 2 ** PW;
    localparam logic [PW-1:0] IDX_CONV = PW'(0);
    localparam logic [PW-1:0] IDX_CFG  = PW'(1);
    localparam logic [PW-1:0] IDX_LO   = PW'(2);
    localparam logic [PW-1:0] IDX_HI   = PW'(3);

    typedef struct packed {
        logic [PW-1:0]             ptr;
        logic [NREGS-1:0][W-1:0]   regs;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (ptr_we_i) d.ptr = ptr_val_i;
        if (wr_we_i && (q.ptr != IDX_CONV)) d.regs[q.ptr] = wr_word_i;
        if (conv_load_i) d.regs[IDX_CONV] = conv_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ptr           <= '0;
            q.regs          <= '0;
            q.regs[IDX_CONV] <= RST_CONV;
            q.regs[IDX_CFG]  <= RST_CFG;
            q.regs[IDX_LO]   <= RST_LO;
            q.regs[IDX_HI]   <= RST_HI;
        end else begin
            q <= d;
        end
    end

    assign rd_word_o = q.regs[q.ptr];
    assign conv_o    = q.regs[IDX_CONV];
    assign cfg_o     = q.regs[IDX_CFG];
    assign lo_o      = q.regs[IDX_LO];
    assign hi_o      = q.regs[IDX_HI];

    AST_CONV_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we_i && !conv_load_i) |=> $stable(conv_o)); // R6
    AST_PTR_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we_i |=> $stable(q.ptr)); // R7
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_we_i, wr_we_i})); // R3
    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_we_i |=> $stable(cfg_o)); // R5

endmodule

// File: rtl/i2cptr_slave.sv
module i2cptr_slave
    import i2cptr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_HI     = 5'b10010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             conv_load,
    input  logic [REG_W-1:0] conv_data,
    output logic [REG_W-1:0] conv_o,
    output logic [REG_W-1:0] cfg_o,
    output logic [REG_W-1:0] lo_thr_o,
    output logic [REG_W-1:0] hi_thr_o
);

    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             ptr_we, wr_we;
    logic [PTR_W-1:0] ptr_val;
    logic [REG_W-1:0] wr_word, rd_word;

    i2cptr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2cptr_engine #(.W(REG_W), .PW(PTR_W), .ASEL_W(2), .ADDR_HI(ADDR_HI)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .addr_sel_i (addr_sel),
        .rd_word_i  (rd_word),
        .sda_oe_o   (sda_oe),
        .ptr_we_o   (ptr_we),
        .ptr_val_o  (ptr_val),
        .wr_we_o    (wr_we),
        .wr_word_o  (wr_word)
    );

    i2cptr_regfile #(.W(REG_W), .PW(PTR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_we_i    (ptr_we),
        .ptr_val_i   (ptr_val),
        .wr_we_i     (wr_we),
        .wr_word_i   (wr_word),
        .conv_load_i (conv_load),
        .conv_data_i (conv_data),
        .rd_word_o   (rd_word),
        .conv_o      (conv_o),
        .cfg_o       (cfg_o),
        .lo_o        (lo_thr_o),
        .hi_o        (hi_thr_o)
    );

endmodule

// File: tb/tb_i2cptr_slave.sv
module tb_i2cptr_slave;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic [1:0]  addr_sel = 2'b01;
    logic        conv_load = 1'b0;
    logic [15:0] conv_data = '0;
    logic        sda_oe;
    logic [15:0] conv_o, cfg_o, lo_thr_o, hi_thr_o;
    logic        sda_bus;

    assign sda_bus = !(m_sda_low || sda_oe);

    always #10 clk = ~clk;

    i2cptr_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .conv_load (conv_load),
        .conv_data (conv_data),
        .conv_o    (conv_o),
        .cfg_o     (cfg_o),
        .lo_thr_o  (lo_thr_o),
        .hi_thr_o  (hi_thr_o)
    );

    typedef struct {
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [15:0] obs_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    task automatic push_exp(input logic [15:0] v, input string tag);
        item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_obs(input logic [15:0] v);
        obs_q.push_back(v);
    endtask

    // Scoreboard monitor
    initial begin
        item_t       e;
        logic [15:0] o;
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                o = obs_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: got %h expected nothing", o);
                end else begin
                    e = exp_q.pop_front();
                    if (o !== e.val) begin
                        errors++;
                        $display("FAIL %s: got %h expected %h", e.tag, o, e.val);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start;
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop;
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda_low = !b; tick(Q);
        m_scl = 1'b1;   tick(Q);
        @(negedge clk);
        s = sda_bus;
        tick(Q);
        m_scl = 1'b0;   tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!m_ack, s);
    endtask

    task automatic check_port(input logic [15:0] actual, input logic [15:0] expv, input string tag);
        push_exp(expv, tag);
        push_obs(actual);
    endtask

    task automatic xfer_write(input logic [6:0] a, input logic [7:0] ptr, input int n,
                              input logic [15:0] data, input logic exp_ack,
                              input bit end_stop, input string tag);
        logic ack;
        bus_start();
        wr_byte({a, 1'b0}, ack);
        check_port({15'b0, ack}, {15'b0, exp_ack}, {tag, " addr ack"});
        wr_byte(ptr, ack);
        check_port({15'b0, ack}, {15'b0, exp_ack}, {tag, " ptr ack"});
        for (int i = 0; i < n; i++) begin
            wr_byte(data[15-8*i -: 8], ack);
            check_port({15'b0, ack}, {15'b0, exp_ack}, {tag, " data ack"});
        end
        if (end_stop) bus_stop();
    endtask

    task automatic xfer_read(input logic [6:0] a, input int n, input logic [15:0] expv,
                             input string tag);
        logic       ack;
        logic [7:0] b;
        bus_start();
        wr_byte({a, 1'b1}, ack);
        check_port({15'b0, ack}, 16'd1, {tag, " read addr ack"});
        for (int i = 0; i < n; i++) begin
            rd_byte(i < n - 1, b);
            check_port({8'b0, b}, {8'b0, expv[15-8*i -: 8]}, {tag, " read byte"});
        end
        @(negedge clk);
        check_port({15'b0, sda_oe}, 16'd0, "R8 released after NACK");
        bus_stop();
    endtask

    task automatic check_views(input logic [15:0] c, input logic [15:0] f,
                               input logic [15:0] l, input logic [15:0] h, input string tag);
        @(negedge clk);
        check_port(conv_o,   c, {tag, " conv"});
        check_port(cfg_o,    f, {tag, " cfg"});
        check_port(lo_thr_o, l, {tag, " lo"});
        check_port(hi_thr_o, h, {tag, " hi"});
    endtask

    task automatic pulse_load(input logic [15:0] v);
        @(negedge clk);
        conv_data = v;
        conv_load = 1'b1;
        @(negedge clk);
        conv_load = 1'b0;
    endtask

    localparam logic [6:0] ADR_A = 7'h49;
    localparam logic [6:0] ADR_B = 7'h4A;

    initial begin
        logic ack;
        logic s;
        logic [7:0] b;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1: reset state
        check_views(16'h0000, 16'h8583, 16'h8000, 16'h7FFF, "R1 reset");
        check_port({15'b0, sda_oe}, 16'd0, "R1 sda released");
        // R1 / R7: pointer starts at the conversion register
        xfer_read(ADR_A, 2, 16'h0000, "R1 R7 default pointer");
        // R9: core load
        pulse_load(16'h1234);
        check_views(16'h1234, 16'h8583, 16'h8000, 16'h7FFF, "R9 load");
        xfer_read(ADR_A, 2, 16'h1234, "R9 read loaded");
        // R5: full word write to index 1
        xfer_write(ADR_A, 8'h01, 2, 16'hA53C, 1'b1, 1'b1, "R5 write cfg");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h7FFF, "R5 after write");
        // R7: pointer persists across reads
        xfer_read(ADR_A, 2, 16'hA53C, "R7 first read");
        xfer_read(ADR_A, 2, 16'hA53C, "R7 repeat read");
        // R4: pointer-only write ended by repeated START
        xfer_write(ADR_A, 8'h02, 0, 16'h0000, 1'b1, 1'b0, "R4 pointer only");
        xfer_read(ADR_A, 2, 16'h8000, "R4 read after repeated start");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h7FFF, "R4 no data change");
        // R3: upper pointer bits ignored
        xfer_write(ADR_A, 8'hFF, 2, 16'h1357, 1'b1, 1'b1, "R3 pointer 0xFF");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h1357, "R3 hi written");
        // R2: other address gets NACK and has no effect
        xfer_write(ADR_B, 8'h01, 2, 16'h0000, 1'b0, 1'b1, "R2 foreign addr");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h1357, "R2 no change");
        xfer_read(ADR_A, 2, 16'h1357, "R2 pointer kept");
        // R5: single data byte then STOP
        xfer_write(ADR_A, 8'h01, 1, 16'h1100, 1'b1, 1'b1, "R5 half word");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h1357, "R5 half word ignored");
        // R6: conversion register is read-only
        xfer_write(ADR_A, 8'h00, 2, 16'hFFFF, 1'b1, 1'b1, "R6 write conv");
        check_views(16'h1234, 16'hA53C, 16'h8000, 16'h1357, "R6 conv unchanged");
        // R8: single byte read with NACK
        xfer_read(ADR_A, 1, 16'h1234, "R8 one byte");
        // R9: load during a read keeps the word coherent
        bus_start();
        wr_byte({ADR_A, 1'b1}, ack);
        check_port({15'b0, ack}, 16'd1, "R9 coherent addr ack");
        fork
            begin
                tick(4 * Q * 3);
                pulse_load(16'hBEEF);
            end
        join_none
        rd_byte(1'b1, b);
        check_port({8'b0, b}, 16'h0012, "R9 coherent high byte");
        rd_byte(1'b0, b);
        check_port({8'b0, b}, 16'h0034, "R9 coherent low byte");
        bus_stop();
        check_views(16'hBEEF, 16'hA53C, 16'h8000, 16'h1357, "R9 load landed");
        xfer_read(ADR_A, 2, 16'hBEEF, "R9 next read");
        // R10: STOP in the middle of a pointer byte
        bus_start();
        wr_byte({ADR_A, 1'b0}, ack);
        check_port({15'b0, ack}, 16'd1, "R10 abort addr ack");
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        bus_stop();
        @(negedge clk);
        check_port({15'b0, sda_oe}, 16'd0, "R10 released after stop");
        xfer_read(ADR_A, 2, 16'hBEEF, "R10 pointer not updated");
        // R2: new address select
        addr_sel = 2'b10;
        tick(4);
        xfer_write(ADR_B, 8'h02, 2, 16'h0F0F, 1'b1, 1'b1, "R2 new address");
        check_views(16'hBEEF, 16'hA53C, 16'h0F0F, 16'h1357, "R2 lo written");
        tick(10);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        tick(4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
        end
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d unmatched expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule